// File: doc/BRIEF.md
# Lane Drive Level Adjust Resolver

During link training, a serial link sink reports a drive adjustment request for each lane it receives: a voltage swing level and a pre-emphasis level. This block turns those requests into one drive setting and applies it to every lane. It takes the largest swing and the largest pre-emphasis asked for by any active lane. It then limits the swing to what the transmitter can produce. Finally, it limits the pre-emphasis so that swing plus pre-emphasis never goes above level 3. A flag in the output records whenever a limit was hit.

The training controller pulses `calc_req` after it has fetched fresh link status. One clock later, the four lane training bytes hold the new setting and `result_valid` pulses for one cycle. A `clr_req` pulse sets every lane byte back to zero; the controller uses it before training starts again. Between requests, the lane bytes keep their value.

Top module: `lane_drive_resolver`

## Requirements
- R1: The swing level is the largest of the swing fields (request nibble bits [1:0]) over lanes 0 to `active_lanes`-1. With `active_lanes` = 0 it is 0.
- R2: Request nibbles of lanes at or above `active_lanes` have no effect on the result.
- R3: The pre-emphasis level is the largest of the pre-emphasis fields (request nibble bits [3:2]) over the active lanes.
- R4: If the chosen swing is at least `swing_ceiling`, the output swing equals `swing_ceiling` and the swing-limit flag (byte bit 2) is 1. Otherwise the flag is 0.
- R5: The pre-emphasis limit is 3 minus the output swing. If the chosen pre-emphasis is at least this limit, the output pre-emphasis equals the limit and the pre-emphasis-limit flag (byte bit 5) is 1. Otherwise the flag is 0.
- R6: All four lane bytes are identical, whatever `active_lanes` is. Lane n sits at `lane_bytes[8n+7:8n]`.
- R7: `clr_req` zeroes all lane bytes at the next clock edge. It wins over a `calc_req` in the same cycle, and no valid pulse follows it.
- R8: A `calc_req` without `clr_req` loads the result at the next edge, and `result_valid` is 1 for exactly that one cycle. With neither request, the lane bytes hold their value.
- R9: Byte layout: bits [1:0] swing, bit 2 swing-limit flag, bits [4:3] pre-emphasis, bit 5 pre-emphasis-limit flag, bits [7:6] always 0.
- R10: While `rst_n` is low, all lane bytes are 0 and `result_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| calc_req | input | 1 | Compute pulse: register a new setting |
| clr_req | input | 1 | Synchronous clear of all lane bytes |
| req_nibbles | input | 16 | Lane n request at [4n+3:4n]: swing [1:0], pre-emphasis [3:2] |
| active_lanes | input | 3 | Number of active lanes, 0 to 4 |
| swing_ceiling | input | 2 | Highest swing level the transmitter supports |
| lane_bytes | output | 32 | Four lane training bytes, lane n at [8n+7:8n] |
| result_valid | output | 1 | One-cycle pulse when a computed setting is loaded |

## Verification
The assertions assume that `active_lanes` never exceeds the number of lanes. They also assume the request inputs are stable around the clock edge. They assume nothing about the request nibbles of inactive lanes, or about how `calc_req` and `clr_req` are combined, so both requests may be high in the same cycle. The bench changes inputs only on the falling edge. It keeps `active_lanes` in the range 0 to 4 and places large values in inactive lanes on purpose. It draws every swing ceiling, including 0. In its random phase it raises `calc_req` and `clr_req` independently, so that both requests overlap in some cycles.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int SW_W    = 2;
  localparam int PE_W    = 2;
  localparam int NIB_W   = SW_W + PE_W;
  localparam int LVL_SUM = 3;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic [1:0]      rsvd;
    logic            pe_hit;
    logic [PE_W-1:0] pe;
    logic            sw_hit;
    logic [SW_W-1:0] sw;
  } drive_set_t;
endpackage

// File: rtl/ldr_req_max.sv
module ldr_req_max
  import ldr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES*NIB_W-1:0] req_nibbles,
  input  logic [CNT_W-1:0]       active_lanes,
  output logic [SW_W-1:0]        sw_peak,
  output logic [PE_W-1:0]        pe_peak
);
  logic [SW_W-1:0] lane_sw [LANES];
  logic [PE_W-1:0] lane_pe [LANES];
  logic [LANES-1:0] lane_on;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sw[g] = req_nibbles[g*NIB_W +: SW_W];
    assign lane_pe[g] = req_nibbles[g*NIB_W + SW_W +: PE_W];
    assign lane_on[g] = (CNT_W'(g) < active_lanes);
  end

  always_comb begin
    sw_peak = '0;
    pe_peak = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_on[i] && (lane_sw[i] > sw_peak)) sw_peak = lane_sw[i];
      if (lane_on[i] && (lane_pe[i] > pe_peak)) pe_peak = lane_pe[i];
    end
  end
endmodule

// File: rtl/ldr_level_clamp.sv
module ldr_level_clamp
  import ldr_pkg::*;
(
  input  logic [SW_W-1:0] sw_peak,
  input  logic [PE_W-1:0] pe_peak,
  input  logic [SW_W-1:0] swing_ceiling,
  output drive_set_t      setting
);
  logic [SW_W-1:0] sw_lim;
  logic            sw_hit;
  logic [PE_W-1:0] pe_ceiling;

  always_comb begin
    sw_hit = (sw_peak >= swing_ceiling);
    sw_lim = sw_hit ? swing_ceiling : sw_peak;
    pe_ceiling = PE_W'(LVL_SUM) - PE_W'(sw_lim);
    setting.rsvd   = '0;
    setting.sw     = sw_lim;
    setting.sw_hit = sw_hit;
    setting.pe_hit = (pe_peak >= pe_ceiling);
    setting.pe     = setting.pe_hit ? pe_ceiling : pe_peak;
  end
endmodule

// File: rtl/ldr_slot_reg.sv
module ldr_slot_reg
  import ldr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    clear,
  input  drive_set_t              setting,
  output logic [LANES*BYTE_W-1:0] lane_bytes,
  output logic                    result_valid
);
  logic            slot_en;
  logic [BYTE_W-1:0] slot_d;
  logic            valid_d;

  always_comb begin
    slot_en = load | clear;
    slot_d  = clear ? '0 : setting;
    valid_d = load & ~clear;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_bytes[g*BYTE_W +: BYTE_W] <= '0;
      else if (slot_en) lane_bytes[g*BYTE_W +: BYTE_W] <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_valid <= 1'b0;
    else        result_valid <= valid_d;
  end
endmodule

// File: rtl/lane_drive_resolver.sv
module lane_drive_resolver
  import ldr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    calc_req,
  input  logic                    clr_req,
  input  logic [LANES*NIB_W-1:0]  req_nibbles,
  input  logic [CNT_W-1:0]        active_lanes,
  input  logic [SW_W-1:0]         swing_ceiling,
  output logic [LANES*BYTE_W-1:0] lane_bytes,
  output logic                    result_valid
);
  logic [SW_W-1:0] sw_peak;
  logic [PE_W-1:0] pe_peak;
  drive_set_t      setting;

  ldr_req_max #(.LANES(LANES)) u_max (
    .req_nibbles (req_nibbles),
    .active_lanes(active_lanes),
    .sw_peak     (sw_peak),
    .pe_peak     (pe_peak)
  );

  ldr_level_clamp u_clamp (
    .sw_peak      (sw_peak),
    .pe_peak      (pe_peak),
    .swing_ceiling(swing_ceiling),
    .setting      (setting)
  );

  ldr_slot_reg #(.LANES(LANES)) u_slots (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (calc_req),
    .clear       (clr_req),
    .setting     (setting),
    .lane_bytes  (lane_bytes),
    .result_valid(result_valid)
  );
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker
  import ldr_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    calc_req,
  input logic                    clr_req,
  input logic [SW_W-1:0]         swing_ceiling,
  input logic [LANES*BYTE_W-1:0] lane_bytes,
  input logic                    result_valid
);
  logic [BYTE_W-1:0] b0;
  logic              slots_same;
  assign b0 = lane_bytes[BYTE_W-1:0];

  always_comb begin
    slots_same = 1'b1;
    for (int i = 1; i < LANES; i++)
      if (lane_bytes[i*BYTE_W +: BYTE_W] != b0) slots_same = 1'b0;
  end

  assert_slots_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slots_same);

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (lane_bytes == '0) && !result_valid);

  assert_valid_after_calc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_req && !clr_req) |=> result_valid);

  assert_no_stray_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(calc_req && !clr_req) |=> !result_valid);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!calc_req && !clr_req) |=> $stable(lane_bytes));

  assert_swing_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_req && !clr_req) |=> (b0[SW_W-1:0] <= $past(swing_ceiling)));

  assert_level_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, b0[1:0]} + {1'b0, b0[4:3]}) <= 3'd3);

  assert_top_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    b0[7:6] == 2'b00);
endmodule

bind lane_drive_resolver ldr_checker #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .calc_req     (calc_req),
  .clr_req      (clr_req),
  .swing_ceiling(swing_ceiling),
  .lane_bytes   (lane_bytes),
  .result_valid (result_valid)
);

// File: tb/lane_drive_resolver_test.sv
module lane_drive_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        calc_req, clr_req;
  logic [15:0] req_nibbles;
  logic [2:0]  active_lanes;
  logic [1:0]  swing_ceiling;
  logic [31:0] lane_bytes;
  logic        result_valid;

  logic [31:0] exp_bytes;
  logic        exp_valid;
  int          n_vec = 0;
  int          n_bad = 0;
  int          cycles = 0;
  bit          finished = 0;

  always #10 clk = ~clk;

  lane_drive_resolver uut (
    .clk(clk), .rst_n(rst_n), .calc_req(calc_req), .clr_req(clr_req),
    .req_nibbles(req_nibbles), .active_lanes(active_lanes),
    .swing_ceiling(swing_ceiling), .lane_bytes(lane_bytes),
    .result_valid(result_valid)
  );

  function automatic logic [7:0] ref_byte(input logic [15:0] nib, input int n, input int smax);
    int s = 0, p = 0, pc;
    logic sf, pf;
    for (int i = 0; i < 4; i++) begin
      if (i < n) begin
        if (int'(nib[4*i +: 2]) > s)   s = int'(nib[4*i +: 2]);
        if (int'(nib[4*i+2 +: 2]) > p) p = int'(nib[4*i+2 +: 2]);
      end
    end
    sf = (s >= smax);
    if (sf) s = smax;
    pc = 3 - s;
    pf = (p >= pc);
    if (pf) p = pc;
    return {2'b00, pf, 2'(p), sf, 2'(s)};
  endfunction

  // Reference model, updated on every clock edge from the applied inputs.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_bytes <= '0;
      exp_valid <= 1'b0;
    end else begin
      exp_valid <= calc_req && !clr_req;
      if (clr_req) exp_bytes <= '0;
      else if (calc_req)
        exp_bytes <= {4{ref_byte(req_nibbles, int'(active_lanes), int'(swing_ceiling))}};
    end
  end

  task automatic check(input string tag);
    n_vec++;
    if (lane_bytes !== exp_bytes || result_valid !== exp_valid) begin
      n_bad++;
      $display("FAIL %s: got bytes=%h valid=%b, expected bytes=%h valid=%b",
               tag, lane_bytes, result_valid, exp_bytes, exp_valid);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic c, input logic z, input logic [15:0] nib,
                      input logic [2:0] n, input logic [1:0] smax, input string tag);
    calc_req = c; clr_req = z; req_nibbles = nib;
    active_lanes = n; swing_ceiling = smax;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++;
        $display("FAIL watchdog: got %0d cycles, expected fewer than 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; calc_req = 0; clr_req = 0;
    req_nibbles = 16'hFFFF; active_lanes = 3'd4; swing_ceiling = 2'd3;
    repeat (3) @(negedge clk);
    check("R10 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release");

    // R1: swing maximum across four lanes (lane2 highest swing 2)
    step(1, 0, 16'h0201, 3'd4, 2'd3, "R1 swing max over lanes");
    step(0, 0, 16'h0201, 3'd4, 2'd3, "R8 valid drops");
    // R2: lane 3 requests swing 3 / pre 3 but only two lanes active
    step(1, 0, 16'hF001, 3'd2, 2'd3, "R2 inactive lanes ignored");
    step(1, 0, 16'hFFFF, 3'd0, 2'd3, "R2 zero lanes active");
    // R3: pre-emphasis max: lane1 pre 2, lane0 pre 1
    step(1, 0, 16'h0084, 3'd4, 2'd3, "R3 pre-emphasis max");
    // R4: swing 3 requested, ceiling 2 -> swing 2 flagged, pre limit 1
    step(1, 0, 16'h0003, 3'd1, 2'd2, "R4 swing clamp");
    step(1, 0, 16'h0001, 3'd1, 2'd2, "R4 below ceiling no flag");
    step(1, 0, 16'h0000, 3'd1, 2'd0, "R4 zero ceiling");
    // R5: swing 1, pre 3 -> pre limited to 2 and flagged
    step(1, 0, 16'h000D, 3'd1, 2'd3, "R5 pre-emphasis clamp");
    step(1, 0, 16'h0005, 3'd1, 2'd3, "R5 pre below limit");
    // R6: one lane active, result still on all four slots
    step(1, 0, 16'hEEE6, 3'd1, 2'd3, "R6 all slots identical");
    // R8: hold while inputs change without a request
    step(0, 0, 16'h3333, 3'd4, 2'd1, "R8 hold idle");
    step(0, 0, 16'hCCCC, 3'd2, 2'd0, "R8 hold idle again");
    // R7: clear, and clear together with compute
    step(0, 1, 16'h3333, 3'd4, 2'd3, "R7 clear zeroes");
    step(1, 0, 16'h3333, 3'd4, 2'd3, "R9 full saturation byte");
    step(1, 1, 16'h3333, 3'd4, 2'd3, "R7 clear wins over compute");

    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 3) != 0, ($urandom % 8) == 0, 16'($urandom),
           3'($urandom % 5), 2'($urandom), "R1 R3 R4 R5 R9 random");
    end

    step(0, 0, 16'h0, 3'd0, 2'd0, "R8 final idle");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule